// File: doc/BRIEF.md
# NAND Flash Page-Copy Sequencer

This block moves a region of a raw NAND flash into a local RAM, one page per pass. For each page it lowers chip-enable and writes the read command through the command latch. It then writes a zero column byte and two row bytes through the address latch. After that it waits for the flash to report ready and reads a full page, word by word, into RAM at an address that counts up. Every page gets a fresh command and row address, so a read never runs on into the spare area that follows the main array.

A one-cycle start pulse loads a byte offset, a length and a RAM base address. The block then runs without further control and ends with a one-cycle done pulse. If the flash stays busy for too long, the transfer stops and an error flag is set. The data bus width is chosen by a parameter. With the default 16-bit bus, the byte offset is halved to form the flash word address and a page holds 256 words. With an 8-bit bus, a page holds 512 bytes. The RAM write port always has the same width as the flash bus.

Top module: `nand_page_copier`

## Requirements
- R1: Every page starts with chip-enable low, the command latch high and one write-strobe pulse carrying the byte 0x00. The write strobe is only ever low while chip-enable is low and either the command latch or the address latch is high.
- R2: The command latch stays high for 1+STRB_LO+STRB_HI+SETTLE_CYC cycles per page, which is 25 with the defaults. The address latch stays high for 3*(1+STRB_LO+STRB_HI)+SETTLE_CYC cycles, which is 35. The two latches are never high together.
- R3: The three address writes carry, in this order: 0x00, then A[15:8], then A[23:16]. Here A is the flash word address: offset>>1 on a 16-bit bus, the offset itself on an 8-bit bus. Page p uses A + p*PAGE_WORDS.
- R4: No read strobe is issued while the ready input is low; the data phase starts only after ready is seen high.
- R5: Each read strobe is low for exactly STRB_LO cycles. The data bus is never driven while the read strobe is low.
- R6: The word on the flash data bus in the last low cycle of each read strobe is written to RAM in the next cycle. RAM addresses run base, base+1, … with no gaps, and the byte-enable is all ones.
- R7: One page is PAGE_WORDS reads. After each page, 512 is subtracted from the remaining length and copying continues while the result is non-negative, so floor(length/512)+1 pages are copied.
- R8: At the end the block raises chip-enable, pulses done for one cycle and drops busy.
- R9: A start pulse that arrives while busy has no effect on the running transfer.
- R10: If ready stays low for TO_LIMIT polling cycles, the transfer is abandoned with no RAM writes: error is set, done pulses and chip-enable rises. Error stays set until the next accepted start clears it.
- R11: After reset all strobes and latches are inactive, chip-enable is high, and done, busy, error and RAM write are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| offset_i | input | 24 | Byte offset into the flash |
| length_i | input | LEN_W | Transfer length in bytes |
| ram_base_i | input | RAM_AW | First RAM word address |
| nand_ce_n_o | output | 1 | Flash chip-enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_dq_o | output | BUS_W | Data to flash |
| nand_dq_oe_o | output | 1 | Drive enable for nand_dq_o |
| nand_dq_i | input | BUS_W | Data from flash |
| nand_rdy_i | input | 1 | Flash ready (high) / busy (low) |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | RAM_AW | RAM word address |
| ram_wdata_o | output | BUS_W | RAM write data |
| ram_be_o | output | BUS_W/8 | RAM byte enables |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Ready-timeout error flag |

## Verification
The results fall due at fixed distances from their stimulus. A RAM write appears in the cycle after the last low cycle of its read strobe, since the capture register adds one stage. The latch lines stay high for fixed counts that follow from the strobe and settle timing. Done comes one cycle after the last page finishes, or TO_LIMIT cycles into an unanswered poll. The bench changes inputs one time unit after the falling edge and samples every output on the falling edge. It checks latch durations and strobe low times as cycle counts, and checks each RAM write on the cycle its enable is high, against a data pattern computed from the row address the requirements predict.

// File: rtl/nand_copy_pkg.sv
// Shared definitions for the NAND page-copy sequencer.
// Assumes a 24-bit flash offset (three address bytes: column, row low, row high).
package nand_copy_pkg;
    localparam int OFF_W = 24;
    localparam logic [7:0] READ_CMD = 8'h00;
    localparam int PAGE_BYTES = 512;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_CMD_WAIT,
        ST_ADDR,
        ST_ADDR_WAIT,
        ST_POLL,
        ST_READ,
        ST_NEXT,
        ST_FIN
    } seq_state_t;
endpackage

// File: rtl/nand_strobe_gen.sv
// One active-low strobe pulse per request: LO cycles low, then HI cycles high.
// Assumes go_i is only raised while idle_o is high. cap_o marks the last low
// cycle (data sampling point); done_o marks the last high cycle.
module nand_strobe_gen #(
    parameter int LO = 2,
    parameter int HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic strb_n_o,
    output logic idle_o,
    output logic cap_o,
    output logic done_o
);
    localparam int MAXC = (LO > HI) ? LO : HI;
    localparam int CW = $clog2(MAXC + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

    phase_t        ph_q;
    logic [CW-1:0] cnt_q;

    // Phase sequencing and per-phase cycle counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (go_i) begin
                    ph_q  <= PH_LOW;
                    cnt_q <= '0;
                end
                PH_LOW: if (cnt_q == CW'(LO - 1)) begin
                    ph_q  <= PH_HIGH;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                PH_HIGH: if (cnt_q == CW'(HI - 1)) begin
                    ph_q  <= PH_IDLE;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign strb_n_o = (ph_q != PH_LOW);
    assign idle_o   = (ph_q == PH_IDLE);
    assign cap_o    = (ph_q == PH_LOW)  && (cnt_q == CW'(LO - 1));
    assign done_o   = (ph_q == PH_HIGH) && (cnt_q == CW'(HI - 1));
endmodule

// File: rtl/nand_wait_ctr.sv
// Saturating cycle counter shared by the settle waits and the ready timeout.
// Assumes clr_i is raised on every state change so each wait starts at zero.
module nand_wait_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    // Count up from zero, holding at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
        end else if (cnt_o != '1) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/nand_page_copier.sv
// NAND page-copy sequencer. Per page: read command, column/row address,
// settle waits, ready poll, PAGE_WORDS strobed reads into RAM, then length
// and flash-address update. Assumes BUS_W is 8 or 16 and that SETTLE_CYC and
// TO_LIMIT fit in TO_W bits.
module nand_page_copier
    import nand_copy_pkg::*;
#(
    parameter int BUS_W      = 16,
    parameter int LEN_W      = 16,
    parameter int RAM_AW     = 16,
    parameter int SETTLE_CYC = 20,
    parameter int STRB_LO    = 2,
    parameter int STRB_HI    = 2,
    parameter int TO_W       = 16,
    parameter int TO_LIMIT   = 65535
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [23:0]         offset_i,
    input  logic [LEN_W-1:0]    length_i,
    input  logic [RAM_AW-1:0]   ram_base_i,
    output logic                nand_ce_n_o,
    output logic                nand_cle_o,
    output logic                nand_ale_o,
    output logic                nand_we_n_o,
    output logic                nand_re_n_o,
    output logic [BUS_W-1:0]    nand_dq_o,
    output logic                nand_dq_oe_o,
    input  logic [BUS_W-1:0]    nand_dq_i,
    input  logic                nand_rdy_i,
    output logic                ram_we_o,
    output logic [RAM_AW-1:0]   ram_addr_o,
    output logic [BUS_W-1:0]    ram_wdata_o,
    output logic [BUS_W/8-1:0]  ram_be_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o
);
    localparam int PAGE_WORDS = (BUS_W == 16) ? 256 : 512;
    localparam int WCW        = $clog2(PAGE_WORDS);

    seq_state_t         state_q, state_d;
    logic [TO_W-1:0]    wait_cnt;
    logic [1:0]         aidx_q;
    logic [WCW-1:0]     wcnt_q;
    logic [OFF_W-1:0]   fla_q, fla_start;
    logic [LEN_W:0]     rem_q, rem_after;
    logic [RAM_AW-1:0]  wptr_q;
    logic               err_q;
    logic               strb_go, strb_n, strb_idle, strb_cap, strb_done;
    logic [7:0]         abyte;
    logic               accept, timeout;

    // Flash word address from byte offset, chosen by bus width.
    generate
        if (BUS_W == 16) begin : g_wide
            logic off_lsb_unused;
            assign off_lsb_unused = offset_i[0];
            assign fla_start = {1'b0, offset_i[OFF_W-1:1]};
        end else begin : g_narrow
            assign fla_start = offset_i;
        end
    endgenerate

    nand_strobe_gen #(.LO(STRB_LO), .HI(STRB_HI)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (strb_go),
        .strb_n_o (strb_n),
        .idle_o   (strb_idle),
        .cap_o    (strb_cap),
        .done_o   (strb_done)
    );

    nand_wait_ctr #(.W(TO_W)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (state_d != state_q),
        .cnt_o (wait_cnt)
    );

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign timeout   = (state_q == ST_POLL) && !nand_rdy_i && (wait_cnt == TO_W'(TO_LIMIT - 1));
    assign rem_after = rem_q - (LEN_W + 1)'(PAGE_BYTES);

    // Next-state selection and strobe requests.
    always_comb begin
        state_d = state_q;
        strb_go = 1'b0;
        case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_CMD;
            ST_CMD: begin
                strb_go = strb_idle;
                if (strb_done) state_d = ST_CMD_WAIT;
            end
            ST_CMD_WAIT:  if (wait_cnt == TO_W'(SETTLE_CYC - 1)) state_d = ST_ADDR;
            ST_ADDR: begin
                strb_go = strb_idle;
                if (strb_done && aidx_q == 2'd2) state_d = ST_ADDR_WAIT;
            end
            ST_ADDR_WAIT: if (wait_cnt == TO_W'(SETTLE_CYC - 1)) state_d = ST_POLL;
            ST_POLL: begin
                if (nand_rdy_i)   state_d = ST_READ;
                else if (timeout) state_d = ST_FIN;
            end
            ST_READ: begin
                strb_go = strb_idle;
                if (strb_done && wcnt_q == WCW'(PAGE_WORDS - 1)) state_d = ST_NEXT;
            end
            ST_NEXT:      state_d = rem_after[LEN_W] ? ST_FIN : ST_CMD;
            ST_FIN:       state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register and transfer bookkeeping (address, length, counters, error).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            aidx_q  <= '0;
            wcnt_q  <= '0;
            fla_q   <= '0;
            rem_q   <= '0;
            wptr_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                fla_q  <= fla_start;
                rem_q  <= {1'b0, length_i};
                wptr_q <= ram_base_i;
                err_q  <= 1'b0;
            end
            if (state_q == ST_CMD) begin
                aidx_q <= '0;
                wcnt_q <= '0;
            end
            if (state_q == ST_ADDR && strb_done) aidx_q <= aidx_q + 1'b1;
            if (state_q == ST_READ && strb_done) wcnt_q <= wcnt_q + 1'b1;
            if (state_q == ST_READ && strb_cap)  wptr_q <= wptr_q + 1'b1;
            if (state_q == ST_NEXT) begin
                rem_q <= rem_after;
                fla_q <= fla_q + OFF_W'(PAGE_WORDS);
            end
            if (timeout) err_q <= 1'b1;
        end
    end

    // RAM write port: register the word sampled at the end of each read low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we_o    <= 1'b0;
            ram_addr_o  <= '0;
            ram_wdata_o <= '0;
        end else begin
            ram_we_o <= (state_q == ST_READ) && strb_cap;
            if ((state_q == ST_READ) && strb_cap) begin
                ram_addr_o  <= wptr_q;
                ram_wdata_o <= nand_dq_i;
            end
        end
    end

    // Address byte for the current address write.
    always_comb begin
        case (aidx_q)
            2'd1:    abyte = fla_q[15:8];
            2'd2:    abyte = fla_q[23:16];
            default: abyte = 8'h00;
        endcase
    end

    assign ram_be_o     = '1;
    assign nand_ce_n_o  = (state_q == ST_IDLE) || (state_q == ST_FIN);
    assign nand_cle_o   = (state_q == ST_CMD)  || (state_q == ST_CMD_WAIT);
    assign nand_ale_o   = (state_q == ST_ADDR) || (state_q == ST_ADDR_WAIT);
    assign nand_dq_oe_o = (state_q == ST_CMD)  || (state_q == ST_ADDR);
    assign nand_dq_o    = (state_q == ST_CMD) ? BUS_W'(READ_CMD) : BUS_W'(abyte);
    assign nand_we_n_o  = strb_n || !nand_dq_oe_o;
    assign nand_re_n_o  = strb_n || (state_q != ST_READ);
    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = (state_q == ST_FIN);
    assign err_o        = err_q;
endmodule

// File: rtl/nand_page_copier_chk.sv
// Protocol checker for nand_page_copier, attached by bind below.
// Assumes it sees only the top-level ports.
module nand_page_copier_chk (
    input logic clk,
    input logic rst_n,
    input logic nand_ce_n_o,
    input logic nand_cle_o,
    input logic nand_ale_o,
    input logic nand_we_n_o,
    input logic nand_re_n_o,
    input logic nand_dq_oe_o,
    input logic ram_we_o,
    input logic done_o,
    input logic busy_o,
    input logic err_o
);
    // R1
    we_in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n_o |-> (!nand_ce_n_o && (nand_cle_o || nand_ale_o)));

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle_o && nand_ale_o));

    // R5
    re_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n_o |-> (!nand_dq_oe_o && nand_we_n_o));

    // R6
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> !$past(nand_re_n_o));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o && nand_ce_n_o));

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);
endmodule

bind nand_page_copier nand_page_copier_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .nand_ce_n_o  (nand_ce_n_o),
    .nand_cle_o   (nand_cle_o),
    .nand_ale_o   (nand_ale_o),
    .nand_we_n_o  (nand_we_n_o),
    .nand_re_n_o  (nand_re_n_o),
    .nand_dq_oe_o (nand_dq_oe_o),
    .ram_we_o     (ram_we_o),
    .done_o       (done_o),
    .busy_o       (busy_o),
    .err_o        (err_o)
);

// File: tb/nand_page_copier_bench.sv
`timescale 1ns/1ps
module nand_page_copier_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LO = 2;
    localparam int HI = 2;
    localparam int SETTLE = 20;
    localparam int TOL = 300;
    localparam int PW = 256;

    typedef struct packed {
        logic [23:0] off;
        logic [15:0] len;
        logic [15:0] base;
        logic [7:0]  busy;
        logic [3:0]  pages;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{24'h000000, 16'd0,    16'h0000, 8'd0,  4'd1},
        '{24'h001000, 16'd511,  16'h0100, 8'd5,  4'd1},
        '{24'h020000, 16'd512,  16'h2000, 8'd30, 4'd2},
        '{24'h03FE00, 16'd1000, 16'hFF80, 8'd3,  4'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [23:0] offset = '0;
    logic [15:0] length = '0;
    logic [15:0] base = '0;
    logic ce_n, cle, ale, we_n, re_n, dq_oe, rdy, ram_we, busy, done, err;
    logic [15:0] dq_o, dq_i, ram_addr, ram_wdata;
    logic [1:0] ram_be;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_page_copier #(.TO_LIMIT(TOL)) u_nand_page_copier (
        .clk(clk), .rst_n(rst_n), .start_i(start), .offset_i(offset),
        .length_i(length), .ram_base_i(base),
        .nand_ce_n_o(ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
        .nand_we_n_o(we_n), .nand_re_n_o(re_n), .nand_dq_o(dq_o),
        .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_i), .nand_rdy_i(rdy),
        .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
        .ram_be_o(ram_be), .busy_o(busy), .done_o(done), .err_o(err)
    );

    // Flash model control, driven only by the main thread
    logic mon_clr = 1'b1;
    logic hang = 1'b0;
    logic [7:0] busy_cfg = '0;
    logic [23:0] exp_a = '0;
    logic [15:0] exp_base = '0;

    // Flash model state
    logic [7:0] m_cmd [4];
    logic [7:0] m_col [4];
    logic [7:0] m_r1 [4];
    logic [7:0] m_r2 [4];
    int m_pg;
    logic [7:0] cur_r1, cur_r2, wr_dq;
    logic [8:0] col;
    logic [1:0] aidx;
    logic pwe, pre;
    int busy_left;

    assign rdy  = hang ? 1'b0 : (busy_left == 0);
    assign dq_i = {cur_r1 ^ cur_r2 ^ 8'h3C, col[7:0]};

    // Flash model: latch command/address on write-strobe rise, advance column on read-strobe rise
    always @(posedge clk) begin
        if (!rst_n || mon_clr) begin
            m_pg <= 0; col <= '0; aidx <= '0; cur_r1 <= '0; cur_r2 <= '0;
            wr_dq <= '0; pwe <= 1'b1; pre <= 1'b1; busy_left <= 0;
            for (int i = 0; i < 4; i++) begin
                m_cmd[i] <= 8'hEE; m_col[i] <= 8'hEE; m_r1[i] <= 8'hEE; m_r2[i] <= 8'hEE;
            end
        end else begin
            pwe <= we_n;
            pre <= re_n;
            if (!we_n) wr_dq <= dq_o[7:0];
            if (busy_left > 0) busy_left <= busy_left - 1;
            if (!pwe && we_n) begin
                if (cle) begin
                    if (m_pg < 4) m_cmd[m_pg] <= wr_dq;
                    col <= '0;
                    aidx <= '0;
                end else if (ale) begin
                    aidx <= aidx + 1'b1;
                    if (m_pg < 4) begin
                        case (aidx)
                            2'd0: m_col[m_pg] <= wr_dq;
                            2'd1: m_r1[m_pg] <= wr_dq;
                            default: m_r2[m_pg] <= wr_dq;
                        endcase
                    end
                    if (aidx == 2'd1) cur_r1 <= wr_dq;
                    if (aidx == 2'd2) begin
                        cur_r2 <= wr_dq;
                        m_pg <= m_pg + 1;
                        busy_left <= int'(busy_cfg);
                    end
                end
            end
            if (!pre && re_n) col <= col + 1'b1;
        end
    end

    // Monitor counters, sampled on the falling edge
    int nw, data_bad, cle_cyc, ale_cyc, re_low, re_busy, done_cnt;
    always @(negedge clk) begin : mon
        logic [23:0] ra;
        logic [15:0] ed;
        if (mon_clr) begin
            nw <= 0; data_bad <= 0; cle_cyc <= 0; ale_cyc <= 0;
            re_low <= 0; re_busy <= 0; done_cnt <= 0;
        end else begin
            if (cle) cle_cyc <= cle_cyc + 1;
            if (ale) ale_cyc <= ale_cyc + 1;
            if (!re_n) re_low <= re_low + 1;
            if (!re_n && !rdy) re_busy <= re_busy + 1;
            if (done) done_cnt <= done_cnt + 1;
            if (ram_we) begin
                ra = exp_a + 24'((nw / PW) * PW);
                ed = {ra[15:8] ^ ra[23:16] ^ 8'h3C, 8'(nw % PW)};
                if (ram_wdata !== ed || ram_addr !== exp_base + 16'(nw) || ram_be !== 2'b11)
                    data_bad <= data_bad + 1;
                nw <= nw + 1;
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic begin_run(input vec_t v);
        step();
        mon_clr = 1'b1;
        busy_cfg = v.busy;
        exp_a = {1'b0, v.off[23:1]};
        exp_base = v.base;
        step();
        mon_clr = 1'b0;
        start = 1'b1; offset = v.off; length = v.len; base = v.base;
        step();
        start = 1'b0;
    endtask

    task automatic wait_done();
        int g = 0;
        while (done_cnt == 0 && g < 20000) begin
            step();
            g++;
        end
        step();
        step();
    endtask

    task automatic check_run(input vec_t v);
        int p = int'(v.pages);
        bit ok_cmd = 1'b1;
        bit ok_row = 1'b1;
        for (int i = 0; i < p && i < 4; i++) begin
            logic [23:0] ra = {1'b0, v.off[23:1]} + 24'(i * PW);
            if (m_cmd[i] != 8'h00 || m_col[i] != 8'h00) ok_cmd = 1'b0;
            if (m_r1[i] != ra[15:8] || m_r2[i] != ra[23:16]) ok_row = 1'b0;
        end
        chk(m_pg == p, "R7 page count", m_pg, p);
        chk(nw == p * PW, "R7 words copied", nw, p * PW);
        chk(ok_cmd, "R1 command 0x00 and column 0 per page", m_cmd[0], 0);
        chk(ok_row, "R3 row address bytes", {m_r2[0], m_r1[0]}, exp_a[23:8]);
        chk(data_bad == 0, "R6 RAM data/address/byte-enable mismatches", data_bad, 0);
        chk(cle_cyc == p * (1 + LO + HI + SETTLE), "R2 command latch cycles", cle_cyc, p * (1 + LO + HI + SETTLE));
        chk(ale_cyc == p * (3 * (1 + LO + HI) + SETTLE), "R2 address latch cycles", ale_cyc, p * (3 * (1 + LO + HI) + SETTLE));
        chk(re_low == nw * LO, "R5 read strobe low cycles", re_low, nw * LO);
        chk(re_busy == 0, "R4 reads while flash busy", re_busy, 0);
        chk(done_cnt == 1 && ce_n && !busy, "R8 done pulse, ce_n high, idle", done_cnt, 1);
        chk(!err, "R10 no error on normal run", err, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) step();
        rst_n = 1'b1;
        step();
        // R11 reset state
        chk(ce_n && !cle && !ale && we_n && re_n && !done && !busy && !err && !ram_we,
            "R11 reset state", {ce_n, cle, ale, we_n, re_n, done, busy, err, ram_we}, 9'b100110000);

        // Table of vectors, one loop
        for (int k = 0; k < 4; k++) begin
            begin_run(VECS[k]);
            wait_done();
            check_run(VECS[k]);
        end

        // R9: start while busy is ignored
        begin_run(VECS[2]);
        repeat (150) step();
        chk(busy, "R9 busy during run", busy, 1);
        start = 1'b1; offset = 24'h000000; length = 16'd0; base = 16'h7777;
        step();
        start = 1'b0;
        wait_done();
        check_run(VECS[2]);

        // R10: ready never rises
        hang = 1'b1;
        begin_run(VECS[0]);
        wait_done();
        chk(err, "R10 error flag after timeout", err, 1);
        chk(nw == 0, "R10 no RAM writes after timeout", nw, 0);
        chk(done_cnt == 1 && ce_n, "R10 done pulse and ce_n high after timeout", done_cnt, 1);
        hang = 1'b0;
        begin_run(VECS[0]);
        wait_done();
        check_run(VECS[0]);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule